// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block turns interrupt events raised by on-chip sources into 16-byte vectors and stores them, one after another, in a circular buffer held in system memory. A host consumes the buffer by reading vectors from its own read position and writing that position back through the register port. The block owns the write position. It raises an interrupt request while unread vectors are waiting. It can also mirror every new write position to a second memory address, so the host can poll memory instead of reading a register.

Both positions are byte offsets into a ring whose size is a power of two. The producer never holds back an event because the ring is full. When it overruns entries the host has not read, it keeps writing, overwrites the oldest entries and raises a sticky overflow flag. That flag is reported in the top bit of the write-position word. After an overflow the host should resume at write position + 16. Software clears the flag through a write-one control bit. The ring runs only while a global interrupt enable and a ring enable are both set. While it is stopped, software may reload both positions.

Top module: `ivr_producer`

## Requirements
- R1: After synchronous reset, irq and mem_valid are 0, ev_ready is 1, and the write-position word (register 6) reads 0.
- R2: A vector is one 128-bit beat on the memory port with mem_be = 16'hFFFF, at address {BASE, 8'h00} + write position. Its bit fields are: [7:0] source id, [59:32] source data, [71:64] ring id, [79:72] VM id, [95:80] address-space id. Every other bit is 0.
- R3: The write position advances by 16 only in the cycle the vector beat is accepted (mem_valid and mem_ready both high). It wraps modulo the ring size of 4 << L bytes, where L is ring-control bits [5:1], clamped to the range 3 to MAX_LOG2.
- R4: irq is high exactly when the global enable is set and either the masked read position differs from the write position or the overflow flag is set.
- R5: Unless global enable (register 0 bit 0) and ring enable (register 1 bit 0) are both 1, accepted events are discarded. No memory write is issued and the write position is unchanged.
- R6: If overflow detection (register 1 bit 9) is set and a vector is committed while (write position + 16) mod size equals the read position, the sticky overflow flag is set. The flag is reported in bit 31 of register 6. With detection off, the flag is not set.
- R7: Writing register 1 with bit 31 = 1 clears the overflow flag. Bit 31 of register 1 always reads 0.
- R8: With writeback enabled (register 1 bit 8), each committed vector is followed by one beat that carries the new write-position word, including its overflow bit, replicated in all four 32-bit lanes. The beat goes to address {WB_HI[7:0], WB_LO with bits [1:0] cleared}, and mem_be enables only the lane selected by address bits [3:2].
- R9: ev_ready is high whenever no memory beat is pending, however full the ring is. A pending beat holds its address, data and byte enables until it is accepted.
- R10: A write to register 6 loads the write position (low 4 bits forced to 0) and clears the flag, but only while the ring is not running. Register 5 (read position) may be written at any time.
- R11: Register offsets on reg_addr: 0 global control, 1 ring control, 2 base (address bits [39:8]), 3 writeback address low, 4 writeback address high, 5 read position, 6 write-position word. Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_src_id | input | 8 | Source identifier |
| ev_src_data | input | 28 | Source payload |
| ev_ring_id | input | 8 | Ring identifier |
| ev_vmid | input | 8 | Virtual machine identifier |
| ev_pasid | input | 16 | Process address-space identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_valid | output | 1 | Memory beat pending |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 128 | Beat data |
| mem_be | output | 16 | Byte enables |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties are checked on every cycle. They cover four behaviours: a stalled memory beat stays stable, the write position moves only on a commit or a software load, the overflow flag stays set until it is cleared, and a writeback beat follows every commit once writeback is on. Properties also check that an event accepted while the ring is stopped never produces a memory beat. Other behaviours need the directed scenarios: the bit placement inside a vector, the wrap at the ring size, the exact cycle in which a full ring turns into an overflow, the lane chosen for the writeback word, and the refusal of a write-position load while running.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int VEC_W     = 128;
    localparam int VEC_BYTES = 16;
    localparam int BE_W      = VEC_W / 8;
    localparam int MIN_LOG2  = 3;

    // register offsets
    localparam logic [2:0] RA_GLOBAL = 3'd0;
    localparam logic [2:0] RA_RING   = 3'd1;
    localparam logic [2:0] RA_BASE   = 3'd2;
    localparam logic [2:0] RA_WB_LO  = 3'd3;
    localparam logic [2:0] RA_WB_HI  = 3'd4;
    localparam logic [2:0] RA_RPTR   = 3'd5;
    localparam logic [2:0] RA_WPTR   = 3'd6;

    // ring-control bit positions
    localparam int RC_EN_BIT   = 0;
    localparam int RC_SIZE_LSB = 1;
    localparam int RC_WB_BIT   = 8;
    localparam int RC_DET_BIT  = 9;
    localparam int RC_CLR_BIT  = 31;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vmid;
        logic [15:0] pasid;
    } ivr_event_t;

    typedef struct packed {
        logic        intr_en;
        logic        ring_en;
        logic [4:0]  size_log2;
        logic        wb_en;
        logic        det_en;
        logic [31:0] base;
        logic [31:0] wb_lo;
        logic [7:0]  wb_hi;
    } ivr_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_WB   = 2'd2
    } ivr_state_t;

    function automatic logic [VEC_W-1:0] pack_vector(input ivr_event_t e);
        logic [VEC_W-1:0] v;
        v         = '0;
        v[7:0]    = e.src_id;
        v[59:32]  = e.src_data;
        v[71:64]  = e.ring_id;
        v[79:72]  = e.vmid;
        v[95:80]  = e.pasid;
        return v;
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [PTR_W-1:0] wptr,
    input  logic             ovf,
    output ivr_cfg_t         cfg,
    output logic [PTR_W-1:0] rptr,
    output logic             ovf_clr,
    output logic             sw_ld,
    output logic [PTR_W-1:0] sw_val
);

    logic running;
    assign running = cfg.intr_en & cfg.ring_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            rptr <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_GLOBAL: cfg.intr_en <= reg_wdata[0];
                RA_RING: begin
                    cfg.ring_en   <= reg_wdata[RC_EN_BIT];
                    cfg.size_log2 <= reg_wdata[RC_SIZE_LSB +: 5];
                    cfg.wb_en     <= reg_wdata[RC_WB_BIT];
                    cfg.det_en    <= reg_wdata[RC_DET_BIT];
                end
                RA_BASE:  cfg.base  <= reg_wdata;
                RA_WB_LO: cfg.wb_lo <= reg_wdata;
                RA_WB_HI: cfg.wb_hi <= reg_wdata[7:0];
                RA_RPTR:  rptr      <= {reg_wdata[PTR_W-1:4], 4'b0000};
                default: ;
            endcase
        end
    end

    assign ovf_clr = reg_wr && (reg_addr == RA_RING) && reg_wdata[RC_CLR_BIT];
    assign sw_ld   = reg_wr && (reg_addr == RA_WPTR) && !running;
    assign sw_val  = reg_wdata[PTR_W-1:0];

    always_comb begin
        case (reg_addr)
            RA_GLOBAL: reg_rdata = {31'b0, cfg.intr_en};
            RA_RING:   reg_rdata = {22'b0, cfg.det_en, cfg.wb_en, 2'b00,
                                    cfg.size_log2, cfg.ring_en};
            RA_BASE:   reg_rdata = cfg.base;
            RA_WB_LO:  reg_rdata = cfg.wb_lo;
            RA_WB_HI:  reg_rdata = {24'b0, cfg.wb_hi};
            RA_RPTR:   reg_rdata = {{(32-PTR_W){1'b0}}, rptr};
            RA_WPTR:   reg_rdata = {ovf, {(31-PTR_W){1'b0}}, wptr};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 14,
    parameter int PTR_W    = MAX_LOG2 + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       size_log2,
    input  logic [PTR_W-1:0] rptr,
    input  logic             det_en,
    input  logic             commit,
    input  logic             ovf_clr,
    input  logic             sw_ld,
    input  logic [PTR_W-1:0] sw_val,
    output logic [PTR_W-1:0] wptr,
    output logic             ovf,
    output logic [PTR_W-1:0] wptr_nxt,
    output logic             ovf_nxt,
    output logic             pending
);

    localparam logic [PTR_W-1:0] STEP  = PTR_W'(VEC_BYTES);
    localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(VEC_BYTES - 1);

    logic [4:0]       eff_log2;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] rptr_m;
    logic             full;

    always_comb begin
        if (int'(size_log2) > MAX_LOG2)      eff_log2 = 5'(MAX_LOG2);
        else if (int'(size_log2) < MIN_LOG2) eff_log2 = 5'(MIN_LOG2);
        else                                 eff_log2 = size_log2;
    end

    // 4 << L bytes; wraps to zero at the maximum, which yields all ones
    assign mask     = (PTR_W'(4) << eff_log2) - PTR_W'(1);
    assign rptr_m   = rptr & mask;
    assign wptr_nxt = (wptr + STEP) & mask;
    assign full     = (wptr_nxt == rptr_m);
    assign ovf_nxt  = ovf | (det_en & full);
    assign pending  = (rptr_m != wptr) | ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            ovf  <= 1'b0;
        end else if (sw_ld) begin
            wptr <= sw_val & mask & ALIGN;
            ovf  <= 1'b0;
        end else begin
            if (commit)
                wptr <= wptr_nxt;
            if (commit && det_en && full)
                ovf <= 1'b1;
            else if (ovf_clr)
                ovf <= 1'b0;
        end
    end

    p_wptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!commit && !sw_ld) |=> $stable(wptr));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr && !sw_ld) |=> ovf);

endmodule

// File: rtl/ivr_wr_fsm.sv
module ivr_wr_fsm
    import ivr_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              wb_en,
    input  logic [31:0]       base,
    input  logic [31:0]       wb_lo,
    input  logic [7:0]        wb_hi,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [PTR_W-1:0]  wptr_nxt,
    input  logic              ovf_nxt,
    input  logic              ev_valid,
    input  ivr_event_t        ev,
    output logic              ev_ready,
    output logic              commit,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VEC_W-1:0]  mem_data,
    output logic [BE_W-1:0]   mem_be
);

    localparam int LANES = VEC_W / 32;

    ivr_state_t        state;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] wb_addr;
    logic [31:0]       wb_word;
    logic [VEC_W-1:0]  wb_data;
    logic [BE_W-1:0]   wb_be;

    assign vec_addr = ADDR_W'({base, 8'h00}) + ADDR_W'(wptr);
    assign wb_addr  = ADDR_W'({wb_hi, wb_lo} & ~40'h3);
    assign wb_word  = {ovf_nxt, {(31-PTR_W){1'b0}}, wptr_nxt};
    assign wb_be    = BE_W'(16'h000F << {wb_addr[3:2], 2'b00});

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wb_data[g*32 +: 32] = wb_word;
    end

    assign ev_ready  = (state == ST_IDLE);
    assign mem_valid = (state != ST_IDLE);
    assign commit    = (state == ST_VEC) && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mem_addr <= '0;
            mem_data <= '0;
            mem_be   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ev_valid && running) begin
                        state    <= ST_VEC;
                        mem_addr <= vec_addr;
                        mem_data <= pack_vector(ev);
                        mem_be   <= '1;
                    end
                end
                ST_VEC: begin
                    if (mem_ready) begin
                        if (wb_en) begin
                            state    <= ST_WB;
                            mem_addr <= wb_addr;
                            mem_data <= wb_data;
                            mem_be   <= wb_be;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ready)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    p_wb_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (commit && wb_en) |=> mem_valid);

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int MAX_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src_id,
    input  logic [27:0]       ev_src_data,
    input  logic [7:0]        ev_ring_id,
    input  logic [7:0]        ev_vmid,
    input  logic [15:0]       ev_pasid,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [127:0]      mem_data,
    output logic [15:0]       mem_be,
    output logic              irq
);

    localparam int PTR_W = MAX_LOG2 + 2;

    ivr_cfg_t         cfg;
    ivr_event_t       ev;
    logic [PTR_W-1:0] rptr, wptr, wptr_nxt, sw_val;
    logic             ovf, ovf_nxt, ovf_clr, sw_ld, commit, pending, running;

    assign ev      = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                       vmid: ev_vmid, pasid: ev_pasid};
    assign running = cfg.intr_en & cfg.ring_en;
    assign irq     = cfg.intr_en & pending;

    ivr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wptr(wptr), .ovf(ovf), .cfg(cfg), .rptr(rptr),
        .ovf_clr(ovf_clr), .sw_ld(sw_ld), .sw_val(sw_val)
    );

    ivr_ptr #(.MAX_LOG2(MAX_LOG2), .PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst(rst),
        .size_log2(cfg.size_log2), .rptr(rptr), .det_en(cfg.det_en),
        .commit(commit), .ovf_clr(ovf_clr), .sw_ld(sw_ld), .sw_val(sw_val),
        .wptr(wptr), .ovf(ovf), .wptr_nxt(wptr_nxt), .ovf_nxt(ovf_nxt), .pending(pending)
    );

    ivr_wr_fsm #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst(rst),
        .running(running), .wb_en(cfg.wb_en), .base(cfg.base),
        .wb_lo(cfg.wb_lo), .wb_hi(cfg.wb_hi),
        .wptr(wptr), .wptr_nxt(wptr_nxt), .ovf_nxt(ovf_nxt),
        .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready), .commit(commit),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be)
    );

    p_drop_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_ready && !running) |=> !mem_valid);

endmodule

// File: tb/test_ivr_producer.sv
`timescale 1ns/1ps
module test_ivr_producer;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ev_valid = 1'b0;
    logic         ev_ready;
    logic [7:0]   ev_src_id = '0;
    logic [27:0]  ev_src_data = '0;
    logic [7:0]   ev_ring_id = '0;
    logic [7:0]   ev_vmid = '0;
    logic [15:0]  ev_pasid = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [39:0]  mem_addr;
    logic [127:0] mem_data;
    logic [15:0]  mem_be;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_wr     = 0;
    logic [39:0]  log_addr [64];
    logic [127:0] log_data [64];
    logic [15:0]  log_be   [64];

    always #2.5 clk = ~clk;

    ivr_producer i_ivr_producer (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
        .ev_vmid(ev_vmid), .ev_pasid(ev_pasid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            log_addr[n_wr % 64] = mem_addr;
            log_data[n_wr % 64] = mem_data;
            log_be[n_wr % 64]   = mem_be;
            n_wr++;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [127:0] exp_vec(input logic [7:0] s, input logic [27:0] p,
                                             input logic [7:0] r, input logic [7:0] v,
                                             input logic [15:0] a);
        logic [127:0] x;
        x = '0;
        x[7:0] = s; x[59:32] = p; x[71:64] = r; x[79:72] = v; x[95:80] = a;
        return x;
    endfunction

    task automatic offer_event(input logic [7:0] s, input logic [27:0] p, input logic [7:0] r,
                               input logic [7:0] v, input logic [15:0] a);
        @(negedge clk);
        ev_src_id = s; ev_src_data = p; ev_ring_id = r; ev_vmid = v; ev_pasid = a;
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!ev_ready) @(negedge clk);
    endtask

    task automatic send_event(input logic [7:0] s, input logic [27:0] p, input logic [7:0] r,
                              input logic [7:0] v, input logic [15:0] a);
        offer_event(s, p, r, v, a);
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 ev_ready", ev_ready, 1);
        reg_read(3'd6, d);
        chk("R1 wptr word", d, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        int n0;
        n0 = n_wr;
        reg_write(3'd1, 32'h0000_000D);
        send_event(8'h11, 28'h1, 8'h1, 8'h1, 16'h1);
        repeat (3) @(negedge clk);
        chk("R5 no write when global enable off", n_wr, n0);
        reg_read(3'd6, d);
        chk("R5 wptr unchanged", d, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        int n0;
        reg_write(3'd2, 32'h0000_1234);
        reg_write(3'd0, 32'h1);
        n0 = n_wr;
        send_event(8'hA5, 28'hABCDEF1, 8'h3C, 8'h07, 16'hBEEF);
        chk("R2 one beat", n_wr, n0 + 1);
        chk("R2 address", log_addr[n0 % 64], 40'h00_0012_3400);
        chk("R2 packing", log_data[n0 % 64], exp_vec(8'hA5, 28'hABCDEF1, 8'h3C, 8'h07, 16'hBEEF));
        chk("R2 byte enables", log_be[n0 % 64], 16'hFFFF);
        reg_read(3'd6, d);
        chk("R3 advance 16", d, 32'h10);
        chk("R4 irq pending", irq, 1);
        reg_write(3'd5, 32'h10);
        @(negedge clk);
        chk("R4 irq idle", irq, 0);
    endtask

    task automatic t_backpressure();
        logic [31:0] d;
        @(negedge clk);
        mem_ready = 1'b0;
        offer_event(8'h22, 28'h2, 8'h2, 8'h2, 16'h2);
        repeat (3) @(negedge clk);
        chk("R9 held valid", mem_valid, 1);
        chk("R9 ready low while pending", ev_ready, 0);
        chk("R9 held address", mem_addr, 40'h00_0012_3410);
        reg_read(3'd6, d);
        chk("R3 no advance before accept", d, 32'h10);
        mem_ready = 1'b1;
        wait_idle();
        reg_read(3'd6, d);
        chk("R3 advance after accept", d, 32'h20);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        int n0;
        reg_write(3'd5, 32'h20);
        reg_write(3'd1, 32'h0000_020D);
        n0 = n_wr;
        for (int i = 0; i < 15; i++) send_event(8'(i), 28'(i), 8'h0, 8'h0, 16'h0);
        chk("R3 address before wrap", log_addr[(n0 + 13) % 64], 40'h00_0012_34F0);
        chk("R3 address after wrap", log_addr[(n0 + 14) % 64], 40'h00_0012_3400);
        reg_read(3'd6, d);
        chk("R3 wrapped wptr, no overflow", d, 32'h10);
        @(negedge clk);
        chk("R9 ready while ring full", ev_ready, 1);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int n0;
        reg_write(3'd3, 32'hABCD_000B);
        reg_write(3'd4, 32'h0000_015A);
        reg_write(3'd1, 32'h0000_030D);
        n0 = n_wr;
        send_event(8'h33, 28'h3, 8'h3, 8'h3, 16'h3);
        chk("R6 vector written over full ring", log_addr[n0 % 64], 40'h00_0012_3410);
        chk("R8 writeback address", log_addr[(n0 + 1) % 64], 40'h5A_ABCD_0008);
        chk("R8 writeback lane", log_be[(n0 + 1) % 64], 16'h0F00);
        chk("R8 writeback word", log_data[(n0 + 1) % 64], {4{32'h8000_0020}});
        reg_read(3'd6, d);
        chk("R6 sticky flag", d, 32'h8000_0020);
        chk("R4 irq on overflow with equal positions", irq, 1);
        reg_write(3'd1, 32'h8000_030D);
        reg_read(3'd6, d);
        chk("R7 flag cleared", d, 32'h20);
        reg_read(3'd1, d);
        chk("R7 clear bit reads 0", d, 32'h30D);
        @(negedge clk);
        chk("R4 irq after clear", irq, 0);
    endtask

    task automatic t_no_detect();
        logic [31:0] d;
        reg_write(3'd1, 32'h0000_010D);
        for (int i = 0; i < 16; i++) send_event(8'h44, 28'(i), 8'h4, 8'h4, 16'h4);
        reg_read(3'd6, d);
        chk("R6 no flag with detection off", d, 32'h20);
        chk("R8 last writeback word", log_data[(n_wr - 1) % 64], {4{32'h0000_0020}});
    endtask

    task automatic t_sw_ptr();
        logic [31:0] d;
        int n0;
        reg_write(3'd6, 32'h40);
        reg_read(3'd6, d);
        chk("R10 load ignored while running", d, 32'h20);
        reg_write(3'd0, 32'h0);
        reg_write(3'd6, 32'h0);
        reg_write(3'd5, 32'h0);
        reg_read(3'd6, d);
        chk("R10 wptr reset", d, 0);
        reg_read(3'd5, d);
        chk("R10 rptr reset", d, 0);
        reg_write(3'd5, 32'h50);
        @(negedge clk);
        chk("R4 irq gated by global enable", irq, 0);
        n0 = n_wr;
        send_event(8'h55, 28'h5, 8'h5, 8'h5, 16'h5);
        repeat (3) @(negedge clk);
        chk("R5 dropped while stopped", n_wr, n0);
        reg_read(3'd7, d);
        chk("R11 unused offset reads 0", d, 0);
        reg_write(3'd0, 32'h1);
        @(negedge clk);
        chk("R4 irq with global enable", irq, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_basic();
        t_backpressure();
        t_wrap();
        t_overflow();
        t_no_detect();
        t_sw_ptr();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule